// File: doc/BRIEF.md
# Dual-Source Bus Ready Synchronizer

This block merges two wait-state terminators into one active-low ready strobe. The strobe is synchronous to the system clock, so the bus master and the bus controller see the same value on the same edge. One input comes from logic that already meets setup and hold to the system clock. The other comes from a device in an unrelated clock domain. Each input has its own active-low enable. Address decode drives these enables to choose which source may end the bus operation in progress.

The block follows the bus from a one-clock start indication. Each bus state (a status state, then one or more command states) lasts two system clocks, called phase 1 and phase 2.

The two sources are sampled at different points:
- The clocked source and its enable are sampled at the edge that ends phase 1 of a command state.
- The foreign source first passes through a two-flop synchronizer. The resolved value and its enable are then captured at the edge that starts a command state. That gives one clock of settling before the value is used.

A termination, from either source, drives the ready strobe low for phase 2 of the command state it ends. A second output shows whether the foreign source caused that termination.

Top module: `dual_ready_sync`

## Requirements
- R1: While reset is held and after it is released, `ready_n` is high and `ready_async` is low until a bus operation is ended.
- R2: `cyc_start` high at a clock edge while the bus is idle starts a status state two clocks long, followed by a command state. `ready_n` stays high through idle clocks, both status clocks and phase 1 of every command state. `cyc_start` has no effect at any other edge.
- R3: `srdy_n` and `srdy_en_n` are sampled at the edge that ends phase 1 of a command state. If both are low there, `ready_n` is low for phase 2 of that command state.
- R4: `ardy_n` passes through two flops. At the edge that starts a command state other than the first, the synchronized value and `ardy_en_n` are captured. If both are low, `ready_n` is low for phase 2 of that command state. As a result, `ardy_n` must be low at least two edges before that start edge.
- R5: The foreign source never ends the first command state of an operation. A zero-wait operation can only be ended by the clocked source.
- R6: A ready input whose enable is high has no effect on `ready_n` or on `ready_async`.
- R7: `ready_n` is low for exactly one clock. After it, the bus leaves the command state. An operation that is not ended repeats command states of two clocks each.
- R8: `ready_async` is high only while `ready_n` is low and the foreign source ended the operation. If both sources qualify in the same command state, the clocked source ends it and `ready_async` stays low.
- R9: `cyc_start` high at the edge that ends the final command state starts the next status state on that same edge, with no idle clock in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; two clocks form one bus state |
| rst_n | input | 1 | Active-low reset |
| cyc_start | input | 1 | Bus operation start indication |
| srdy_n | input | 1 | Clocked ready, active low |
| srdy_en_n | input | 1 | Enable for the clocked ready, active low |
| ardy_n | input | 1 | Ready from a foreign clock domain, active low |
| ardy_en_n | input | 1 | Enable for the foreign ready, active low |
| ready_n | output | 1 | Merged ready strobe, active low, marks the last command state |
| ready_async | output | 1 | High while `ready_n` is low and the foreign source ended the operation |

## Verification
Two things can fall in the same command state: a clocked termination and a foreign termination. They are provoked directly by holding both sources and both enables active for a whole operation. Random traffic also drives them together often. When they coincide, `ready_n` must fall in the first command state and `ready_async` must stay low.

A second overlap is an operation ending on the same edge that a new start indication arrives. This is exercised by chaining operations with no idle clock. The judgement is that the next status state and its command states keep their exact two-clock timing.

// File: rtl/dual_ready_sync.sv
module dual_ready_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic srdy_n,
  input  logic srdy_en_n,
  input  logic ardy_n,
  input  logic ardy_en_n,
  output logic ready_n,
  output logic ready_async
);

  localparam int LAST = SYNC_STAGES - 1;

  typedef enum logic [1:0] {ST_IDLE, ST_STAT, ST_CMD} bus_st_t;

  bus_st_t          st;
  logic             ph2;
  logic             first_cmd;
  logic [LAST:0]    apipe;
  logic             acap;
  logic             rdy_q;
  logic             src_a;

  logic s_hit, a_hit;
  assign s_hit = ~srdy_n & ~srdy_en_n;
  assign a_hit = ~apipe[LAST] & ~ardy_en_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ph2       <= 1'b0;
      first_cmd <= 1'b0;
      apipe     <= '1;
      acap      <= 1'b0;
      rdy_q     <= 1'b0;
      src_a     <= 1'b0;
    end else begin
      apipe <= {apipe[LAST-1:0], ardy_n};
      case (st)
        ST_IDLE: begin
          ph2 <= 1'b0;
          if (cyc_start) st <= ST_STAT;
        end
        ST_STAT: begin
          if (!ph2) ph2 <= 1'b1;
          else begin
            st        <= ST_CMD;
            ph2       <= 1'b0;
            first_cmd <= 1'b1;
            acap      <= 1'b0;
          end
        end
        default: begin
          if (!ph2) begin
            ph2   <= 1'b1;
            rdy_q <= s_hit | acap;
            src_a <= acap & ~s_hit;
          end else if (rdy_q) begin
            rdy_q     <= 1'b0;
            src_a     <= 1'b0;
            ph2       <= 1'b0;
            first_cmd <= 1'b0;
            st        <= cyc_start ? ST_STAT : ST_IDLE;
          end else begin
            ph2       <= 1'b0;
            first_cmd <= 1'b0;
            acap      <= a_hit;
          end
        end
      endcase
    end
  end

  assign ready_n     = ~rdy_q;
  assign ready_async = src_a;

  assert_stat_two_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STAT && !ph2) |=> (st == ST_STAT && ph2));

  assert_ready_only_cmd_ph2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_n |-> (st == ST_CMD && ph2));

  assert_sync_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_n && !ready_async) |-> $past(!srdy_n && !srdy_en_n));

  assert_async_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready_async |-> !$past(ardy_en_n, 2));

  assert_no_zero_wait_async_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (first_cmd && !ready_n) |-> !ready_async);

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_n |=> (ready_n && st != ST_CMD));

  assert_flag_with_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_async |-> !ready_n);

  assert_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_n && cyc_start) |=> (st == ST_STAT && !ph2));

endmodule

// File: tb/sim_dual_ready_sync.sv
module sim_dual_ready_sync;
  logic clk = 1'b0, rst_n = 1'b0, cyc_start = 1'b0;
  logic srdy_n = 1'b1, srdy_en_n = 1'b1, ardy_n = 1'b1, ardy_en_n = 1'b1;
  logic ready_n, ready_async;
  int n_chk = 0, n_fail = 0;
  bit ah [0:15];
  bit aeh[0:15];
  localparam int FORCE_AT = 6;

  dual_ready_sync u0 (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
    .srdy_n(srdy_n), .srdy_en_n(srdy_en_n),
    .ardy_n(ardy_n), .ardy_en_n(ardy_en_n),
    .ready_n(ready_n), .ready_async(ready_async)
  );

  always #2 clk = ~clk;

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit src_hit(bit r_n, bit e_n);
    return !r_n && !e_n;
  endfunction

  task automatic drive(int mode, int k);
    case (mode)
      1: begin srdy_n = 1; srdy_en_n = 0; ardy_n = 0; ardy_en_n = 0; end
      2: begin srdy_n = 0; srdy_en_n = 0; ardy_n = 0; ardy_en_n = 0; end
      3: begin srdy_n = 0; srdy_en_n = 1; ardy_n = 0; ardy_en_n = 1; end
      default: begin
        srdy_n    = ($urandom_range(0, 3) != 0);
        srdy_en_n = $urandom_range(0, 1);
        ardy_n    = ($urandom_range(0, 2) == 0);
        ardy_en_n = $urandom_range(0, 1);
      end
    endcase
    if (k >= FORCE_AT) begin srdy_n = 0; srdy_en_n = 0; end
    cyc_start = $urandom_range(0, 1);
  endtask

  task automatic bus_op(int mode, bit chain, string ts_req);
    bit s, a, masked;
    @(posedge clk);
    @(negedge clk);
    drive(mode, -1); ah[0] = ardy_n; aeh[0] = ardy_en_n;
    chk(ts_req, ready_n, 1'b1);
    @(posedge clk);
    @(negedge clk);
    chk(ts_req, ready_n, 1'b1);
    chk("R2", ready_async, 1'b0);
    for (int k = 0; k < 12; k++) begin
      @(posedge clk);
      @(negedge clk);
      drive(mode, k); ah[k+1] = ardy_n; aeh[k+1] = ardy_en_n;
      chk("R7 phase1", ready_n, 1'b1);
      s = src_hit(srdy_n, srdy_en_n);
      a = 1'b0;
      if (k > 0) a = src_hit(ah[k-1], aeh[k]);
      masked = (!srdy_n && srdy_en_n) || (k > 0 && !ah[k-1] && aeh[k]);
      @(posedge clk);
      @(negedge clk);
      if (k == 0)            chk("R5", ready_n, !s);
      else if (a && !s)      chk("R4", ready_n, 1'b0);
      else if (masked && !s) chk("R6", ready_n, !a);
      else                   chk("R3", ready_n, !(s || a));
      chk("R8", ready_async, a && !s);
      if (s || a) begin
        cyc_start = chain;
        break;
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit ch;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", ready_n, 1'b1);
    chk("R1", ready_async, 1'b0);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      ardy_n = 0; ardy_en_n = 0; srdy_n = 0; srdy_en_n = 0;
      chk("R1", ready_n, 1'b1);
      chk("R1", ready_async, 1'b0);
    end
    for (int m = 1; m <= 3; m++) begin
      cyc_start = 1'b1;
      bus_op(m, 1'b0, "R2");
      @(negedge clk);
      chk("R7", ready_n, 1'b1);
    end
    cyc_start = 1'b1;
    bus_op(2, 1'b1, "R2");
    bus_op(1, 1'b1, "R9");
    bus_op(0, 1'b0, "R9");
    @(negedge clk);
    chk("R7", ready_n, 1'b1);
    ch = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (!ch) begin
        @(negedge clk);
        cyc_start = 1'b1;
      end
      ch = $urandom_range(0, 2) == 0;
      bus_op(0, ch, ch ? "R9" : "R2");
      if (!ch) begin
        @(negedge clk);
        chk("R7", ready_n, 1'b1);
        cyc_start = 1'b0;
        ardy_n = $urandom_range(0, 1);
        srdy_n = $urandom_range(0, 1);
        srdy_en_n = 1'b0;
        @(negedge clk);
        chk("R2", ready_n, 1'b1);
      end
    end
    @(negedge clk);
    cyc_start = 1'b0;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule